// File: doc/BRIEF.md
# Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link for a device that stores 16-bit words. A client gives it one command at a time on a valid/ready port: read a word, write a word, arm writes, or disarm writes. The block builds the serial frame, produces chip select, the serial clock and the outgoing data bit, samples the returning data line, and ends every command with a one-cycle done pulse. The pulse comes with the read word and an error flag.

The block keeps the device protocol correct on its own. It remembers whether writes are armed and refuses a write that is not armed, without sending a frame. It holds chip select low for a programmable minimum time between frames. After a write it lets the device program, then raises select again and watches the data line until the device reports ready. If that takes longer than a programmable limit, it gives up and flags an error. The serial clock rate comes from a divider of the system clock.

Top module: `mw_eeprom_host`

## Requirements
- R1: `cmd_ready` is high only while no command is in progress. It goes low on the cycle after a command is accepted and stays low until the cycle after `rsp_done`. `rsp_done` is high for exactly one cycle per accepted command.
- R2: Each frame starts with a 1, then a 2-bit opcode, then the ADDR_W-bit address, all MSB first. Read uses opcode 10. Write uses opcode 01 and is followed by the 16 data bits D15 first. Arm and disarm use opcode 00, with the address field starting 11 (arm) or 00 (disarm) and the rest 0. Command codes on `cmd_op` are 0 read, 1 write, 2 arm, 3 disarm.
- R3: Each serial clock bit has a low half and a high half of SK_HALF system cycles each. `ee_mosi` changes only while `ee_sck` is low. `ee_sck` is low whenever `ee_cs` is low.
- R4: A read clocks 1 dummy bit and then 16 data bits. Each bit is sampled on the falling serial clock edge. `rsp_rdata` holds D15..D0 when `rsp_done` pulses.
- R5: Writes are disarmed after reset and after a disarm command, and armed after an arm command. A write issued while disarmed sends no frame and leaves the memory unchanged. Its `rsp_done` comes on the cycle after acceptance with `rsp_err`=1.
- R6: Chip select stays low for at least CS_GAP system cycles between any two frames, and after the last frame before `rsp_done`.
- R7: After the last write data bit, chip select drops for CS_GAP cycles and then rises again. The data line is then polled each cycle. The first 1 seen ends the poll, and the command ends with `rsp_err`=0.
- R8: If the data line is still 0 BUSY_MAX cycles after chip select dropped at the end of a write, polling stops with `rsp_err`=1.
- R9: A frame of N serial bits that does not poll ends with `rsp_done` N*2*SK_HALF+CS_GAP cycles after the acceptance edge. N is 13 for arm and disarm and 30 for read.
- R10: During reset and right after it, `cmd_ready` is 1 and `ee_cs`, `ee_sck`, `ee_mosi` and `rsp_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle and accepting |
| cmd_op | input | 2 | 0 read, 1 write, 2 arm, 3 disarm |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Word to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Word read, valid with `rsp_done` after a read |
| rsp_err | output | 1 | Write refused or busy poll timed out |
| ee_cs | output | 1 | Device chip select, active high |
| ee_sck | output | 1 | Serial clock |
| ee_mosi | output | 1 | Serial data to device |
| ee_miso | input | 1 | Serial data from device |

## Verification
A refused write must give its done pulse at the first falling system edge after the acceptance edge. Arm, disarm and read must give theirs exactly 13 or 30 bit periods plus CS_GAP cycles later. The bench counts falling edges from acceptance and compares against these exact counts. Write completion depends on how long the device model stays busy, so those cases are checked only against a lower bound: the model's busy time, or BUSY_MAX on timeout. The device model reacts on falling system edges, and all outputs are sampled on falling edges, so every value compared is one the controller registered on the preceding rising edge.

// File: rtl/mw_eeprom_host.sv
`timescale 1ns/1ps
module mw_eeprom_host #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int SK_HALF  = 4,
  parameter int CS_GAP   = 32,
  parameter int BUSY_MAX = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              ee_cs,
  output logic              ee_sck,
  output logic              ee_mosi,
  input  logic              ee_miso
);
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int RD_BITS = HDR_W + 1 + DATA_W;
  localparam int TW      = $clog2((SK_HALF > CS_GAP ? SK_HALF : CS_GAP) + 1);
  localparam int BW      = $clog2(BUSY_MAX + 1);
  localparam int NW      = $clog2(RD_BITS + 1);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_ARM = 2'd2, OP_DIS = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_MID, S_POLL, S_TAIL, S_DONE} st_t;
  st_t st;

  logic [FRAME_W-1:0] tx;
  logic [DATA_W-1:0]  rx;
  logic [TW-1:0]      tcnt;
  logic [BW-1:0]      tmo;
  logic [NW-1:0]      nbits, bidx;
  logic [1:0]         op_q;
  logic               armed, sk_q, err_q;

  wire half_end = (tcnt == TW'(SK_HALF - 1));
  wire gap_end  = (tcnt == TW'(CS_GAP - 1));

  assign cmd_ready = (st == S_IDLE);
  assign rsp_done  = (st == S_DONE);
  assign rsp_rdata = rx;
  assign rsp_err   = err_q;
  assign ee_cs     = (st == S_SHIFT) || (st == S_POLL);
  assign ee_sck    = sk_q;
  assign ee_mosi   = (st == S_SHIFT) & tx[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tx <= '0; rx <= '0; tcnt <= '0; tmo <= '0;
      nbits <= '0; bidx <= '0; op_q <= OP_RD;
      armed <= 1'b0; sk_q <= 1'b0; err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q <= cmd_op;
          tcnt <= '0;
          bidx <= '0;
          if (cmd_op == OP_WR && !armed) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else begin
            err_q <= 1'b0;
            st    <= S_SHIFT;
            case (cmd_op)
              OP_RD:   begin tx <= {3'b110, cmd_addr, {DATA_W{1'b0}}}; nbits <= NW'(RD_BITS); end
              OP_WR:   begin tx <= {3'b101, cmd_addr, cmd_wdata};      nbits <= NW'(FRAME_W); end
              OP_ARM:  begin tx <= {3'b100, 2'b11, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}}; nbits <= NW'(HDR_W); end
              default: begin tx <= {3'b100, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};            nbits <= NW'(HDR_W); end
            endcase
          end
        end
        S_SHIFT: begin
          tcnt <= half_end ? '0 : tcnt + 1'b1;
          if (half_end) begin
            if (!sk_q) sk_q <= 1'b1;
            else begin
              sk_q <= 1'b0;
              rx   <= {rx[DATA_W-2:0], ee_miso};
              tx   <= {tx[FRAME_W-2:0], 1'b0};
              bidx <= bidx + 1'b1;
              if (bidx == nbits - 1'b1) begin
                tmo <= '0;
                st  <= (op_q == OP_WR) ? S_MID : S_TAIL;
              end
            end
          end
        end
        S_MID: begin
          tcnt <= tcnt + 1'b1;
          tmo  <= tmo + 1'b1;
          if (gap_end) st <= S_POLL;
        end
        S_POLL: begin
          tmo  <= tmo + 1'b1;
          tcnt <= '0;
          if (ee_miso) st <= S_TAIL;
          else if (tmo >= BW'(BUSY_MAX - 1)) begin
            err_q <= 1'b1;
            st    <= S_TAIL;
          end
        end
        S_TAIL: begin
          tcnt <= tcnt + 1'b1;
          if (gap_end) begin
            if (op_q == OP_ARM) armed <= 1'b1;
            if (op_q == OP_DIS) armed <= 1'b0;
            st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_host_chk.sv
`timescale 1ns/1ps
module mw_eeprom_host_chk #(
  parameter int CS_GAP = 32
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic rsp_done,
  input logic ee_cs,
  input logic ee_sck,
  input logic ee_mosi
);
  int low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= CS_GAP;
    else if (ee_cs) low_cnt <= 0;
    else if (low_cnt < CS_GAP) low_cnt <= low_cnt + 1;
  end

  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !ee_cs |-> !ee_sck);
  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (ee_sck && $past(ee_sck)) |-> $stable(ee_mosi));
  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done);
  // R6
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_cs) |-> (low_cnt >= CS_GAP));
  // R6
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |-> (!ee_cs && low_cnt >= CS_GAP));
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_done(rsp_done), .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_mosi(ee_mosi)
);

// File: tb/tb_mw_eeprom_host.sv
`timescale 1ns/1ps
module tb_mw_eeprom_host;
  localparam int SKH = 2, GAP = 5, BMAX = 400, PROG = 60;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [9:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic rsp_done, rsp_err, ee_cs, ee_sck, ee_mosi;
  logic [15:0] rsp_rdata;
  logic m_do = 1'b0;

  mw_eeprom_host #(.ADDR_W(10), .DATA_W(16), .SK_HALF(SKH), .CS_GAP(GAP), .BUSY_MAX(BMAX)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_mosi(ee_mosi), .ee_miso(m_do));

  int n_chk = 0, n_bad = 0;
  bit reported = 0;

  // Device model, evaluated on falling system edges
  logic [15:0] mem [0:1023];
  logic [28:0] m_sr;
  int m_bits = 0, m_gap = 1000, m_busy = 0, frames = 0, wr_frames = 0;
  int gap_viol = 0, sck_viol = 0, mosi_viol = 0;
  bit m_arm = 0, m_rd = 0, m_pend = 0, m_hang = 0, p_cs = 0, p_sck = 0, p_mosi = 0;
  logic [9:0] m_ra, m_pa;
  logic [15:0] m_pd;

  initial for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;

  always @(negedge clk) begin
    if (!ee_cs && ee_sck) sck_viol++;
    if (ee_sck && p_sck && ee_mosi !== p_mosi) mosi_viol++;
    if (ee_cs && !p_cs) begin
      if (m_gap < GAP) gap_viol++;
      frames++; m_bits = 0; m_sr = '0; m_rd = 0;
    end
    if (!ee_cs && p_cs && m_bits == 29 && m_sr[27:26] == 2'b01) begin
      wr_frames++;
      if (m_arm) begin m_busy = PROG; m_pend = 1; m_pa = m_sr[25:16]; m_pd = m_sr[15:0]; end
    end
    m_gap = ee_cs ? 0 : m_gap + 1;
    if (ee_cs && ee_sck && !p_sck) begin
      m_sr = {m_sr[27:0], ee_mosi};
      m_bits++;
      if (m_bits == 13 && m_sr[12]) begin
        if (m_sr[11:10] == 2'b10) begin m_rd = 1; m_ra = m_sr[9:0]; end
        if (m_sr[11:8] == 4'b0011) m_arm = 1;
        if (m_sr[11:8] == 4'b0000) m_arm = 0;
      end
      if (m_rd && m_bits == 14) m_do = 1'b0;
      else if (m_rd && m_bits >= 15 && m_bits <= 30) m_do = mem[m_ra][30 - m_bits];
    end
    if (!m_hang && m_busy > 0) begin
      m_busy--;
      if (m_busy == 0 && m_pend) begin mem[m_pa] = m_pd; m_pend = 0; end
    end
    if (!ee_cs) m_do = 1'b0;
    else if (m_bits == 0) m_do = (m_busy == 0);
    p_cs = ee_cs; p_sck = ee_sck; p_mosi = ee_mosi;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [9:0] a, input logic [15:0] d,
                       output logic [15:0] rd, output logic er, output int n);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1", "ready after accept", cmd_ready, 0);
    n = 0;
    while (!rsp_done) begin @(negedge clk); n++; end
    rd = rsp_rdata; er = rsp_err;
    @(negedge clk);
    chk(!rsp_done, "R1", "done single cycle", rsp_done, 0);
    chk(cmd_ready, "R1", "ready after done", cmd_ready, 1);
  endtask

  task automatic t_reset();
    chk(cmd_ready === 1'b1, "R10", "ready in reset", cmd_ready, 1);
    chk({ee_cs, ee_sck, ee_mosi, rsp_done} === 4'b0, "R10", "outputs in reset", {ee_cs, ee_sck, ee_mosi, rsp_done}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_ready === 1'b1 && ee_cs === 1'b0, "R10", "idle after reset", {cmd_ready, ee_cs}, 2);
  endtask

  task automatic t_locked_write();
    logic [15:0] rd; logic er; int n; int f0 = frames;
    issue(2'd1, 10'h00A, 16'hBEEF, rd, er, n);
    chk(er == 1'b1, "R5", "err on disarmed write", er, 1);
    chk(n == 0, "R5", "refused write latency", n, 0);
    chk(frames == f0, "R5", "no frame sent", frames, f0);
    chk(mem[10'h00A] == 16'h0000, "R5", "memory untouched", mem[10'h00A], 0);
  endtask

  task automatic t_arm();
    logic [15:0] rd; logic er; int n;
    issue(2'd2, 10'h000, 16'h0, rd, er, n);
    chk(er == 1'b0, "R2", "arm err", er, 0);
    chk(m_arm == 1'b1, "R2", "device saw arm frame", m_arm, 1);
    chk(n == 13 * 2 * SKH + GAP, "R9", "arm latency", n, 13 * 2 * SKH + GAP);
  endtask

  task automatic t_write_read(input logic [9:0] a, input logic [15:0] d);
    logic [15:0] rd; logic er; int n; int w0 = wr_frames;
    issue(2'd1, a, d, rd, er, n);
    chk(er == 1'b0, "R7", "write err", er, 0);
    chk(wr_frames == w0 + 1, "R2", "write frame decoded", wr_frames, w0 + 1);
    chk(n >= 29 * 2 * SKH + GAP + PROG, "R7", "polled until ready", n, 29 * 2 * SKH + GAP + PROG);
    chk(mem[a] == d, "R2", "device word", mem[a], d);
    issue(2'd0, a, 16'h0, rd, er, n);
    chk(rd == d && er == 1'b0, "R4", "read back", rd, d);
    chk(n == 30 * 2 * SKH + GAP, "R9", "read latency", n, 30 * 2 * SKH + GAP);
  endtask

  task automatic t_disarm();
    logic [15:0] rd; logic er; int n; int f0;
    issue(2'd3, 10'h000, 16'h0, rd, er, n);
    chk(m_arm == 1'b0 && er == 1'b0, "R2", "device saw disarm", m_arm, 0);
    f0 = frames;
    issue(2'd1, 10'h3FF, 16'h1234, rd, er, n);
    chk(er == 1'b1 && frames == f0, "R5", "write after disarm refused", {er, frames[7:0]}, {1'b1, f0[7:0]});
    issue(2'd0, 10'h3FF, 16'h0, rd, er, n);
    chk(rd == 16'h8001, "R5", "word kept after refused write", rd, 16'h8001);
  endtask

  task automatic t_timeout();
    logic [15:0] rd; logic er; int n;
    issue(2'd2, 10'h000, 16'h0, rd, er, n);
    m_hang = 1;
    issue(2'd1, 10'h077, 16'h5555, rd, er, n);
    chk(er == 1'b1, "R8", "timeout err", er, 1);
    chk(n >= 29 * 2 * SKH + BMAX, "R8", "timeout wait", n, 29 * 2 * SKH + BMAX);
    m_hang = 0; m_busy = 0; m_pend = 0;
    issue(2'd1, 10'h078, 16'h0F0F, rd, er, n);
    chk(er == 1'b0 && mem[10'h078] == 16'h0F0F, "R7", "write after timeout", mem[10'h078], 16'h0F0F);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_locked_write();
    t_arm();
    t_write_read(10'h005, 16'hA5C3);
    t_write_read(10'h3FF, 16'h8001);
    t_write_read(10'h200, 16'h7FFE);
    t_disarm();
    t_timeout();
    chk(gap_viol == 0, "R6", "select gap violations", gap_viol, 0);
    chk(sck_viol == 0, "R3", "clock while deselected", sck_viol, 0);
    chk(mosi_viol == 0, "R3", "data moved with clock high", mosi_viol, 0);
    report();
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule